// File: doc/BRIEF.md
# Flash Protected-Range Checker

This block sits in front of a serial flash cycle engine and decides, for every access request, whether the cycle may start. It holds five programmable windows. Each window covers a span of whole 4 KB pages and has two enables. One enable blocks writes and erases inside the span. The other blocks reads inside it. Software fills the windows through a small register port and then asserts a lock input. From that point the windows are frozen and enforced.

Each request carries a 25-bit byte address and a flag that tells a read from a write/erase. The request is judged in the clock cycle it is presented. In the next cycle it appears either on the forward port, which carries the unchanged address and type, or as a one-cycle violation pulse. A blocked request also sets a sticky error flag. Software clears that flag by writing a one to it.

Top module: `flash_range_guard`

## Requirements
- R1: After synchronous reset, every window reads back as zero, the status word reads zero (unlocked, no violation), and no forward or violation output is active.
- R2: Window words at indices 0 to 4 hold the write/erase enable in bit 31, the upper page number (address bits 24:12) in bits 28:16, the read enable in bit 15 and the lower page number in bits 12:0. Bits 30:29 and 14:13 always read as zero, so writing all ones reads back as 32'h9FFF_9FFF.
- R3: While unlocked, every request is forwarded regardless of the window contents.
- R4: When locked, a write/erase request is blocked if its address lies in the inclusive range {lower,12'h000} to {upper,12'hFFF} of any window whose bit 31 is set.
- R5: When locked, a read request is blocked only by windows whose bit 15 is set. A window with only bit 31 set does not block reads, and a window with only bit 15 set does not block writes.
- R6: Windows combine by OR: a request is blocked when at least one enabled window covers it, also where windows overlap.
- R7: A request presented at one clock edge produces, at the next edge, exactly one of these: fwd_valid with the same address and type, or viol_pulse. A blocked request is never forwarded.
- R8: A blocked request sets viol_flag (status bit 0). The flag stays set until a register write to index 5 with data bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set. When a set and a clear fall in the same cycle, the set wins.
- R9: A one-cycle pulse on lock_in sets the lock (status bit 1). Only reset clears the lock. While locked, writes to window words are ignored.
- R10: A window whose lower page is above its upper page covers no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0-4 windows, 5 status |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| lock_in | input | 1 | Lock-down request, sticky once seen |
| req_valid | input | 1 | Access request present |
| req_addr | input | 25 | Byte address of the request |
| req_is_write | input | 1 | 1 = write/erase, 0 = read |
| fwd_valid | output | 1 | Allowed request forwarded (one cycle later) |
| fwd_addr | output | 25 | Forwarded address |
| fwd_is_write | output | 1 | Forwarded type |
| viol_pulse | output | 1 | Request was blocked (one cycle later) |
| viol_flag | output | 1 | Sticky violation flag |
| locked | output | 1 | Lock-down state |

## Verification
The hardest behaviour to reach is what the block does after lock. Windows can only be loaded before the lock, and nothing except reset releases it. For that reason the stimulus loads a deliberately awkward set of windows first: a single page, the top of the address space, an inverted span, and overlapping read windows with different enables. It then proves the lock has frozen them, and only after that sweeps every one of the 8192 pages with both access types. The sweep alternates the first and last byte of each page, so that every inclusive edge is exercised.

// File: rtl/frg_pkg.sv
package frg_pkg;

    localparam int ADDR_W     = 25;
    localparam int PAGE_W     = 12;
    localparam int LIM_W      = ADDR_W - PAGE_W;
    localparam int DATA_W     = 32;
    localparam int NUM_RANGES = 5;
    localparam int IDX_W      = 3;
    localparam int STATUS_IDX = NUM_RANGES;

    localparam int WP_BIT = 31;
    localparam int RP_BIT = 15;
    localparam int UP_LSB = 16;
    localparam int LO_LSB = 0;

    localparam int ST_VIOL_BIT = 0;
    localparam int ST_LOCK_BIT = 1;

    typedef struct packed {
        logic             wr_prot;
        logic             rd_prot;
        logic [LIM_W-1:0] upper;
        logic [LIM_W-1:0] lower;
    } range_t;

    typedef struct packed {
        logic              valid;
        logic              is_write;
        logic [ADDR_W-1:0] addr;
    } req_t;

    function automatic range_t unpack_range(logic [DATA_W-1:0] w);
        range_t r;
        r.wr_prot = w[WP_BIT];
        r.rd_prot = w[RP_BIT];
        r.upper   = w[UP_LSB +: LIM_W];
        r.lower   = w[LO_LSB +: LIM_W];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_range(range_t r);
        logic [DATA_W-1:0] w;
        w                  = '0;
        w[WP_BIT]          = r.wr_prot;
        w[RP_BIT]          = r.rd_prot;
        w[UP_LSB +: LIM_W] = r.upper;
        w[LO_LSB +: LIM_W] = r.lower;
        return w;
    endfunction

    function automatic logic [LIM_W-1:0] page_of(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:PAGE_W];
    endfunction

endpackage

// File: rtl/frg_range_bank.sv
module frg_range_bank
    import frg_pkg::*;
#(
    parameter int N = NUM_RANGES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  locked,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output range_t [N-1:0]        ranges
);

    for (genvar i = 0; i < N; i++) begin : g_entry
        logic hit_idx;
        assign hit_idx = cfg_we && !locked && (cfg_addr == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ranges[i] <= '0;
            end else if (hit_idx) begin
                ranges[i] <= unpack_range(cfg_wdata);
            end
        end
    end

endmodule

// File: rtl/frg_window_match.sv
module frg_window_match
    import frg_pkg::*;
#(
    parameter int N = NUM_RANGES
) (
    input  req_t           req,
    input  range_t [N-1:0] ranges,
    output logic [N-1:0]   hits,
    output logic           any_hit
);

    logic [LIM_W-1:0] page;
    assign page = page_of(req.addr);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic above_lo, below_hi, en;
        assign above_lo = (page >= ranges[i].lower);
        assign below_hi = (page <= ranges[i].upper);
        assign en       = req.is_write ? ranges[i].wr_prot : ranges[i].rd_prot;
        assign hits[i]  = req.valid && en && above_lo && below_hi;
    end

    assign any_hit = |hits;

endmodule

// File: rtl/frg_status.sv
module frg_status (
    input  logic clk,
    input  logic rst,
    input  logic lock_req,
    input  logic viol_set,
    input  logic viol_clr,
    output logic locked,
    output logic viol_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked    <= 1'b0;
            viol_flag <= 1'b0;
        end else begin
            if (lock_req) begin
                locked <= 1'b1;
            end
            if (viol_set) begin
                viol_flag <= 1'b1;
            end else if (viol_clr) begin
                viol_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
    import frg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic [DATA_W-1:0]     cfg_rdata,
    input  logic                  lock_in,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_is_write,
    output logic                  fwd_valid,
    output logic [ADDR_W-1:0]     fwd_addr,
    output logic                  fwd_is_write,
    output logic                  viol_pulse,
    output logic                  viol_flag,
    output logic                  locked
);

    range_t [NUM_RANGES-1:0] ranges;
    req_t                    cur_req;
    logic [NUM_RANGES-1:0]   hits;
    logic                    any_hit;
    logic                    block_now;
    logic                    allow_now;
    logic                    clr_req;

    assign cur_req.valid    = req_valid;
    assign cur_req.is_write = req_is_write;
    assign cur_req.addr     = req_addr;

    frg_range_bank #(.N(NUM_RANGES)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .locked    (locked),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ranges    (ranges)
    );

    frg_window_match #(.N(NUM_RANGES)) u_match (
        .req     (cur_req),
        .ranges  (ranges),
        .hits    (hits),
        .any_hit (any_hit)
    );

    assign block_now = req_valid && locked && any_hit;
    assign allow_now = req_valid && !block_now;
    assign clr_req   = cfg_we && (cfg_addr == IDX_W'(STATUS_IDX)) && cfg_wdata[ST_VIOL_BIT];

    frg_status u_status (
        .clk       (clk),
        .rst       (rst),
        .lock_req  (lock_in),
        .viol_set  (block_now),
        .viol_clr  (clr_req),
        .locked    (locked),
        .viol_flag (viol_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_valid    <= 1'b0;
            fwd_addr     <= '0;
            fwd_is_write <= 1'b0;
            viol_pulse   <= 1'b0;
        end else begin
            fwd_valid  <= allow_now;
            viol_pulse <= block_now;
            if (allow_now) begin
                fwd_addr     <= req_addr;
                fwd_is_write <= req_is_write;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (cfg_addr == IDX_W'(i)) begin
                cfg_rdata = pack_range(ranges[i]);
            end
        end
        if (cfg_addr == IDX_W'(STATUS_IDX)) begin
            cfg_rdata[ST_VIOL_BIT] = viol_flag;
            cfg_rdata[ST_LOCK_BIT] = locked;
        end
    end

endmodule

// File: rtl/frg_checker.sv
module frg_checker
    import frg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_addr,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              req_valid,
    input logic              fwd_valid,
    input logic              viol_pulse,
    input logic              viol_flag,
    input logic              locked
);

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fwd_valid && viol_pulse));

    a_r7_needs_request: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (fwd_valid || viol_pulse));

    a_r3_unlocked_pass: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !locked) |=> fwd_valid);

    a_r8_flag_follows: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |-> viol_flag);

    a_r8_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !cfg_we) |=> viol_flag);

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr < IDX_W'(NUM_RANGES)) |->
            (cfg_rdata[30:29] == 2'b00 && cfg_rdata[14:13] == 2'b00));

endmodule

bind flash_range_guard frg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_rdata  (cfg_rdata),
    .req_valid  (req_valid),
    .fwd_valid  (fwd_valid),
    .viol_pulse (viol_pulse),
    .viol_flag  (viol_flag),
    .locked     (locked)
);

// File: tb/tb_flash_range_guard.sv
module tb_flash_range_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lock_in = 1'b0;
    logic        req_valid = 1'b0;
    logic [24:0] req_addr = '0;
    logic        req_is_write = 1'b0;
    logic        fwd_valid;
    logic [24:0] fwd_addr;
    logic        fwd_is_write;
    logic        viol_pulse;
    logic        viol_flag;
    logic        locked;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_reg [5];
    bit          m_locked = 0;
    bit          m_flag = 0;

    localparam logic [31:0] KEEP = 32'h9FFF_9FFF;

    always #2.5 clk = ~clk;

    flash_range_guard dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lock_in(lock_in),
        .req_valid(req_valid), .req_addr(req_addr), .req_is_write(req_is_write),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_is_write(fwd_is_write),
        .viol_pulse(viol_pulse), .viol_flag(viol_flag), .locked(locked)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [2:0] idx, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 5 && !m_locked) m_reg[idx] = d & KEEP;
        if (idx == 5 && d[0]) m_flag = 0;
    endtask

    task automatic cfg_check(string tag, logic [2:0] idx, logic [31:0] exp);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_addr = idx;
        #1;
        chk(tag, {32'd0, cfg_rdata}, {32'd0, exp});
    endtask

    function automatic bit model_block(logic [24:0] a, bit wr);
        logic [12:0] pg;
        pg = a[24:12];
        if (!m_locked) return 0;
        for (int i = 0; i < 5; i++) begin
            bit en;
            en = wr ? m_reg[i][31] : m_reg[i][15];
            if (en && pg >= m_reg[i][12:0] && pg <= m_reg[i][28:16]) return 1;
        end
        return 0;
    endfunction

    task automatic req(string tag, logic [24:0] a, bit wr);
        bit blk;
        logic [63:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is_write = wr;
        blk = model_block(a, wr);
        if (blk) m_flag = 1;
        @(posedge clk);
        #1;
        exp = {35'd0, !blk, blk, m_flag, (!blk) & wr, blk ? 25'd0 : a};
        chk(tag, {35'd0, fwd_valid, viol_pulse, viol_flag,
                  fwd_is_write & fwd_valid, fwd_valid ? fwd_addr : 25'd0}, exp);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk(bit wp, bit rp, logic [12:0] hi, logic [12:0] lo);
        return {wp, 2'b00, hi, rp, 2'b00, lo};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1;
        chk("R1 outputs", {60'd0, fwd_valid, viol_pulse, viol_flag, locked}, 64'd0);
        for (int i = 0; i < 6; i++) cfg_check("R1 readback", 3'(i), 32'd0);

        // R2: reserved bits read zero
        cfg_write(3'd4, 32'hFFFF_FFFF);
        cfg_check("R2 reserved", 3'd4, 32'h9FFF_9FFF);

        // Window set: single page, top of space, inverted, overlapping reads
        cfg_write(3'd0, mk(1, 0, 13'h001F, 13'h0010));
        cfg_write(3'd1, mk(0, 1, 13'h0100, 13'h0100));
        cfg_write(3'd2, mk(1, 1, 13'h1FFF, 13'h1FF0));
        cfg_write(3'd3, mk(1, 0, 13'h0400, 13'h0500));
        cfg_write(3'd4, mk(0, 1, 13'h0120, 13'h00F0));
        for (int i = 0; i < 5; i++) cfg_check("R2 readback", 3'(i), m_reg[i]);

        // R3: unlocked, everything passes
        for (int p = 0; p < 8192; p += 37) begin
            req("R3 unlocked", {13'(p), 12'h000}, 1);
            req("R3 unlocked", {13'(p), 12'hFFF}, 0);
        end
        idle();

        // R9: lock and freeze
        @(negedge clk);
        lock_in = 1'b1;
        @(negedge clk);
        lock_in = 1'b0;
        m_locked = 1;
        cfg_check("R9 lock status", 3'd5, 32'h2);
        cfg_write(3'd0, 32'd0);
        cfg_check("R9 frozen", 3'd0, mk(1, 0, 13'h001F, 13'h0010));
        lock_in = 1'b0;
        repeat (2) @(negedge clk);
        cfg_check("R9 still locked", 3'd5, 32'h2);

        // R4: inclusive write edges
        req("R4 below", 25'h000_FFFF, 1);
        req("R4 lower edge", 25'h001_0000, 1);
        req("R4 upper edge", 25'h001_FFFF, 1);
        req("R4 above", 25'h002_0000, 1);
        req("R4 top", 25'h1FF_FFFF, 1);
        // R5: type separation
        req("R5 read in write window", 25'h001_8000, 0);
        req("R5 write in read window", 25'h010_0000, 1);
        req("R5 read single page", 25'h010_0ABC, 0);
        // R6: overlap and OR
        req("R6 overlap", 25'h010_0000, 0);
        req("R6 second only", 25'h00F_5000, 0);
        // R10: inverted window
        req("R10 inverted", 25'h045_0000, 1);
        idle();

        // R8: sticky flag and clear
        cfg_check("R8 flag set", 3'd5, 32'h3);
        cfg_write(3'd5, 32'h0);
        cfg_check("R8 write zero", 3'd5, 32'h3);
        cfg_write(3'd5, 32'h1);
        cfg_check("R8 cleared", 3'd5, 32'h2);
        req("R8 allowed keeps clear", 25'h003_0000, 1);
        req("R8 block sets", 25'h001_2345, 1);
        idle();
        cfg_write(3'd5, 32'h1);

        // R7: full sweep, every page, both types, both page edges
        for (int p = 0; p < 8192; p++) begin
            logic [11:0] off;
            off = (p % 2 == 1) ? 12'hFFF : 12'h000;
            req("R7 sweep write R4", {13'(p), off}, 1);
            req("R7 sweep read R5", {13'(p), ~off}, 0);
        end
        idle();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule